// File: doc/BRIEF.md
# BCD Calendar Counter with Century Flag

This block holds the running time of day and calendar for a real-time clock. Each accepted one-second tick moves the seconds field forward, and overflow ripples through minutes, hours, weekday, day of month, month and year. All fields are held as two-digit packed BCD, except the weekday, which is a 3-bit binary value from 1 to 7. The day-of-month limit follows the current month, and February is lengthened in leap years. A century flag can be set to flip whenever the year wraps.

A register front end writes a complete time snapshot in one cycle through the load port. That same load also writes the halt flag, which is the only way to start or freeze the count. The block leaves reset halted, so software has to load a valid time with the halt flag clear before any tick has an effect. A one-cycle strobe marks each second that was actually counted, and later stages can use it to refresh readable copies of the time.

Top module: `rtcc_calendar_core`

## Requirements
- R1: When the seconds field (BCD, 00..59) wraps from 59 to 00, the minutes field (00..59) steps. When minutes wrap from 59 to 00, the hours field (00..23) steps. Hours wrap from 23 to 00.
- R2: When hours wrap, the weekday and the day of month both step in the same cycle. The weekday counts 1..7 and follows 7 with 1.
- R3: The day of month wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, after 30 in months 04, 06, 09 and 11, and after 28 in month 02. In month 02 it wraps after 29 instead when the year's value is a multiple of four, with year 00 counted as leap. A day wrap steps the month (01..12), and a month wrap from 12 to 01 steps the year (00..99).
- R4: When the year wraps from 99 to 00 and the century-enable input is 1, the century flag inverts. When century-enable is 0, the century flag is never changed by counting.
- R5: While the halt flag is 1, ticks change no field and raise no strobe. Once a load clears the flag, the very next tick advances the time.
- R6: After reset the fields read 00:00:00, weekday 1, day 01, month 01, year 00, century 0, halt flag 1 and strobe 0.
- R7: A load pulse writes every field, the century flag and the halt flag at the same time. The written values appear on the outputs in the next cycle. A tick in the same cycle as a load is discarded and raises no strobe.
- R8: The strobe is high for exactly the one cycle that follows each tick that advanced the time.
- R9: In a cycle with neither a tick nor a load, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second advance request, one cycle wide |
| cen_en_i | input | 1 | Lets the century flag flip when the year wraps |
| load_i | input | 1 | Writes all load fields this cycle |
| ld_sec_i | input | 8 | Seconds to load, BCD |
| ld_min_i | input | 8 | Minutes to load, BCD |
| ld_hour_i | input | 8 | Hours to load, BCD |
| ld_dow_i | input | 3 | Weekday to load, 1..7 |
| ld_date_i | input | 8 | Day of month to load, BCD |
| ld_month_i | input | 8 | Month to load, BCD |
| ld_year_i | input | 8 | Year to load, BCD |
| ld_century_i | input | 1 | Century flag to load |
| ld_stop_i | input | 1 | Halt flag to load |
| sec_o | output | 8 | Current seconds, BCD |
| min_o | output | 8 | Current minutes, BCD |
| hour_o | output | 8 | Current hours, BCD |
| dow_o | output | 3 | Current weekday |
| date_o | output | 8 | Current day of month, BCD |
| month_o | output | 8 | Current month, BCD |
| year_o | output | 8 | Current year, BCD |
| century_o | output | 1 | Century flag |
| stop_o | output | 1 | Halt flag |
| sec_stb_o | output | 1 | Strobe for a counted second |

## Verification
Some rules are local and hold cycle by cycle, so properties check them on every clock. These are the freeze while halted, the hold in idle cycles, load priority together with its exact values, the strobe's link to an accepted tick, the century flag staying put while disabled, and the seconds wrap carrying into minutes. The month-length table, the leap-year rule, the weekday wrap, the year wrap with the century flip, and long runs of carries depend on calendar knowledge. Only the bench scenarios can show those, because they compare against an independent integer calendar model.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
    localparam int BCD_W = 8;
    localparam int DOW_W = 3;

    typedef logic [BCD_W-1:0] bcd_t;
    typedef logic [DOW_W-1:0] dow_t;

    localparam bcd_t BCD_ZERO   = 8'h00;
    localparam bcd_t BCD_ONE    = 8'h01;
    localparam bcd_t SEC_LAST   = 8'h59;
    localparam bcd_t MIN_LAST   = 8'h59;
    localparam bcd_t HOUR_LAST  = 8'h23;
    localparam bcd_t MONTH_LAST = 8'h12;
    localparam bcd_t YEAR_LAST  = 8'h99;
    localparam dow_t DOW_FIRST  = 3'd1;
    localparam dow_t DOW_LAST   = 3'd7;

    typedef struct packed {
        logic century;
        bcd_t year;
        bcd_t month;
        bcd_t date;
        dow_t dow;
        bcd_t hour;
        bcd_t minute;
        bcd_t second;
    } cal_t;

    typedef struct packed {
        cal_t cal;
        logic stop;
        logic stb;
    } core_t;
endpackage

// File: rtl/rtcc_bcd_field.sv
module rtcc_bcd_field
    import rtcc_pkg::*;
(
    input  bcd_t cur_i,
    input  logic inc_i,
    input  bcd_t first_i,
    input  bcd_t last_i,
    output bcd_t nxt_o,
    output logic carry_o
);
    logic at_last;
    bcd_t bumped;

    always_comb begin
        // A value at or past the limit wraps, so an out-of-range load recovers.
        at_last = (cur_i >= last_i);
        if (cur_i[3:0] >= 4'd9) begin
            bumped = {cur_i[7:4] + 4'd1, 4'd0};
        end else begin
            bumped = {cur_i[7:4], cur_i[3:0] + 4'd1};
        end
        carry_o = inc_i & at_last;
        if (!inc_i) begin
            nxt_o = cur_i;
        end else if (at_last) begin
            nxt_o = first_i;
        end else begin
            nxt_o = bumped;
        end
    end
endmodule

// File: rtl/rtcc_month_end.sv
module rtcc_month_end
    import rtcc_pkg::*;
(
    input  bcd_t month_i,
    input  bcd_t year_i,
    output bcd_t last_date_o,
    output logic leap_o
);
    logic [6:0] year_bin;

    always_comb begin
        year_bin = ({3'b000, year_i[7:4]} * 7'd10) + {3'b000, year_i[3:0]};
        leap_o   = (year_bin[1:0] == 2'b00);           // R3: multiple of four, 00 included
        unique case (month_i)
            8'h02:                      last_date_o = leap_o ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date_o = 8'h30;
            default:                    last_date_o = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtcc_calendar_core.sv
module rtcc_calendar_core
    import rtcc_pkg::*;
#(
    parameter logic RESET_STOP = 1'b1
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       cen_en_i,
    input  logic       load_i,
    input  logic [7:0] ld_sec_i,
    input  logic [7:0] ld_min_i,
    input  logic [7:0] ld_hour_i,
    input  logic [2:0] ld_dow_i,
    input  logic [7:0] ld_date_i,
    input  logic [7:0] ld_month_i,
    input  logic [7:0] ld_year_i,
    input  logic       ld_century_i,
    input  logic       ld_stop_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [2:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic       century_o,
    output logic       stop_o,
    output logic       sec_stb_o
);
    core_t st_q, st_d;

    logic adv;
    logic sec_cy, min_cy, hour_cy, date_cy, month_cy, year_cy;
    logic leap;
    bcd_t sec_n, min_n, hour_n, date_n, month_n, year_n, date_last;

    assign adv = tick_i & ~st_q.stop & ~load_i;           // R5 R7

    rtcc_month_end i_mend (
        .month_i(st_q.cal.month), .year_i(st_q.cal.year),
        .last_date_o(date_last), .leap_o(leap)
    );

    rtcc_bcd_field i_sec (
        .cur_i(st_q.cal.second), .inc_i(adv), .first_i(BCD_ZERO),
        .last_i(SEC_LAST), .nxt_o(sec_n), .carry_o(sec_cy)
    );
    rtcc_bcd_field i_min (
        .cur_i(st_q.cal.minute), .inc_i(sec_cy), .first_i(BCD_ZERO),
        .last_i(MIN_LAST), .nxt_o(min_n), .carry_o(min_cy)
    );
    rtcc_bcd_field i_hour (
        .cur_i(st_q.cal.hour), .inc_i(min_cy), .first_i(BCD_ZERO),
        .last_i(HOUR_LAST), .nxt_o(hour_n), .carry_o(hour_cy)
    );
    rtcc_bcd_field i_date (
        .cur_i(st_q.cal.date), .inc_i(hour_cy), .first_i(BCD_ONE),
        .last_i(date_last), .nxt_o(date_n), .carry_o(date_cy)
    );
    rtcc_bcd_field i_month (
        .cur_i(st_q.cal.month), .inc_i(date_cy), .first_i(BCD_ONE),
        .last_i(MONTH_LAST), .nxt_o(month_n), .carry_o(month_cy)
    );
    rtcc_bcd_field i_year (
        .cur_i(st_q.cal.year), .inc_i(month_cy), .first_i(BCD_ZERO),
        .last_i(YEAR_LAST), .nxt_o(year_n), .carry_o(year_cy)
    );

    always_comb begin
        st_d            = st_q;
        st_d.stb        = adv;                             // R8
        st_d.cal.second = sec_n;                           // R1
        st_d.cal.minute = min_n;
        st_d.cal.hour   = hour_n;
        st_d.cal.date   = date_n;                          // R3
        st_d.cal.month  = month_n;
        st_d.cal.year   = year_n;
        if (hour_cy) begin                                 // R2
            st_d.cal.dow = (st_q.cal.dow >= DOW_LAST) ? DOW_FIRST : st_q.cal.dow + 3'd1;
        end
        if (year_cy && cen_en_i) begin                     // R4
            st_d.cal.century = ~st_q.cal.century;
        end
        if (load_i) begin                                  // R7
            st_d.cal.second  = ld_sec_i;
            st_d.cal.minute  = ld_min_i;
            st_d.cal.hour    = ld_hour_i;
            st_d.cal.dow     = ld_dow_i;
            st_d.cal.date    = ld_date_i;
            st_d.cal.month   = ld_month_i;
            st_d.cal.year    = ld_year_i;
            st_d.cal.century = ld_century_i;
            st_d.stop        = ld_stop_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin                                  // R6
            st_q             <= '0;
            st_q.cal.dow     <= DOW_FIRST;
            st_q.cal.date    <= BCD_ONE;
            st_q.cal.month   <= BCD_ONE;
            st_q.stop        <= RESET_STOP;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o     = st_q.cal.second;
    assign min_o     = st_q.cal.minute;
    assign hour_o    = st_q.cal.hour;
    assign dow_o     = st_q.cal.dow;
    assign date_o    = st_q.cal.date;
    assign month_o   = st_q.cal.month;
    assign year_o    = st_q.cal.year;
    assign century_o = st_q.cal.century;
    assign stop_o    = st_q.stop;
    assign sec_stb_o = st_q.stb;
endmodule

// File: rtl/rtcc_calendar_checker.sv
module rtcc_calendar_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       cen_en_i,
    input logic       load_i,
    input logic [7:0] ld_sec_i,
    input logic [7:0] ld_min_i,
    input logic [7:0] ld_hour_i,
    input logic [2:0] ld_dow_i,
    input logic [7:0] ld_date_i,
    input logic [7:0] ld_month_i,
    input logic [7:0] ld_year_i,
    input logic       ld_century_i,
    input logic       ld_stop_i,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [2:0] dow_o,
    input logic [7:0] date_o,
    input logic [7:0] month_o,
    input logic [7:0] year_o,
    input logic       century_o,
    input logic       stop_o,
    input logic       sec_stb_o
);
    logic [52:0] snap;
    assign snap = {century_o, year_o, month_o, date_o, dow_o, hour_o, min_o, sec_o};

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_o && !load_i) |=> ($stable(snap) && !sec_stb_o)); // R5

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (sec_o == $past(ld_sec_i) && min_o == $past(ld_min_i) &&
                    hour_o == $past(ld_hour_i) && dow_o == $past(ld_dow_i) &&
                    date_o == $past(ld_date_i) && month_o == $past(ld_month_i) &&
                    year_o == $past(ld_year_i) && century_o == $past(ld_century_i) &&
                    stop_o == $past(ld_stop_i) && !sec_stb_o)); // R7

    AST_STB_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        sec_stb_o |-> $past(tick_i && !load_i && !stop_o)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> ($stable(snap) && $stable(stop_o) && !sec_stb_o)); // R9

    AST_CENTURY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_en_i && !load_i) |=> $stable(century_o)); // R4

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && !stop_o && sec_o == 8'h59) |=> (sec_o == 8'h00 && !$stable(min_o))); // R1
endmodule

bind rtcc_calendar_core rtcc_calendar_checker i_chk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cen_en_i(cen_en_i), .load_i(load_i),
    .ld_sec_i(ld_sec_i), .ld_min_i(ld_min_i), .ld_hour_i(ld_hour_i), .ld_dow_i(ld_dow_i),
    .ld_date_i(ld_date_i), .ld_month_i(ld_month_i), .ld_year_i(ld_year_i),
    .ld_century_i(ld_century_i), .ld_stop_i(ld_stop_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o),
    .month_o(month_o), .year_o(year_o), .century_o(century_o), .stop_o(stop_o),
    .sec_stb_o(sec_stb_o)
);

// File: tb/test_rtcc_calendar_core.sv
`timescale 1ns/1ps
module test_rtcc_calendar_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0, cen_en_i = 1'b0, load_i = 1'b0;
    logic [7:0] ld_sec_i = '0, ld_min_i = '0, ld_hour_i = '0, ld_date_i = '0, ld_month_i = '0, ld_year_i = '0;
    logic [2:0] ld_dow_i = '0;
    logic       ld_century_i = 1'b0, ld_stop_i = 1'b0;
    logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o;
    logic [2:0] dow_o;
    logic       century_o, stop_o, sec_stb_o;

    always #2.5 clk = ~clk;

    rtcc_calendar_core i_rtcc_calendar_core (.*);

    typedef struct { logic [55:0] v; string tag; } exp_t;
    exp_t sb_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // independent calendar model, binary integers
    int m_sec, m_min, m_hour, m_dow, m_date, m_month, m_year, m_cent, m_stop;

    function automatic int to_bcd(int v);
        return ((v / 10) * 16) + (v % 10);
    endfunction

    function automatic int days_in(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [55:0] snap(bit stb);
        return {stb, m_stop[0], m_cent[0], 8'(to_bcd(m_year)), 8'(to_bcd(m_month)),
                8'(to_bcd(m_date)), 3'(m_dow), 8'(to_bcd(m_hour)), 8'(to_bcd(m_min)),
                8'(to_bcd(m_sec))};
    endfunction

    function automatic void model_step();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hour++;
                if (m_hour == 24) begin
                    m_hour = 0;
                    m_dow  = (m_dow == 7) ? 1 : m_dow + 1;
                    m_date++;
                    if (m_date > days_in(m_month, m_year)) begin
                        m_date = 1; m_month++;
                        if (m_month == 13) begin
                            m_month = 1; m_year++;
                            if (m_year == 100) begin
                                m_year = 0;
                                if (cen_en_i) m_cent ^= 1;
                            end
                        end
                    end
                end
            end
        end
    endfunction

    task automatic push(bit stb, string tag);
        exp_t e;
        e.v = snap(stb);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic do_idle(string tag);
        @(negedge clk);
        tick_i = 1'b0; load_i = 1'b0;
        push(0, tag);
    endtask

    task automatic do_tick(string tag);
        bit acc;
        @(negedge clk);
        tick_i = 1'b1; load_i = 1'b0;
        acc = (m_stop == 0);
        if (acc) model_step();
        push(acc, tag);
    endtask

    task automatic do_load(int s, int mi, int h, int dw, int dt, int mo, int y,
                           int c, int st, bit tk, string tag);
        @(negedge clk);
        ld_sec_i = 8'(to_bcd(s)); ld_min_i = 8'(to_bcd(mi)); ld_hour_i = 8'(to_bcd(h));
        ld_dow_i = 3'(dw); ld_date_i = 8'(to_bcd(dt)); ld_month_i = 8'(to_bcd(mo));
        ld_year_i = 8'(to_bcd(y)); ld_century_i = c[0]; ld_stop_i = st[0];
        load_i = 1'b1; tick_i = tk;
        m_sec = s; m_min = mi; m_hour = h; m_dow = dw; m_date = dt; m_month = mo;
        m_year = y; m_cent = c; m_stop = st;
        push(0, tag);
    endtask

    // monitor: compares one expected item per cycle after the edge settles
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            logic [55:0] got;
            e = sb_q.pop_front();
            got = {sec_stb_o, stop_o, century_o, year_o, month_o, date_o, dow_o,
                   hour_o, min_o, sec_o};
            n_checks++;
            if (got !== e.v) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", e.tag, got, e.v);
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        m_sec = 0; m_min = 0; m_hour = 0; m_dow = 1; m_date = 1; m_month = 1;
        m_year = 0; m_cent = 0; m_stop = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        do_idle("R6 reset values");
        do_idle("R9 idle hold");
        do_tick("R5 tick while halted after reset");
        do_tick("R5 second tick while halted");

        // R7 load with a coincident tick: tick discarded
        cen_en_i = 1'b1;
        do_load(58, 59, 23, 7, 31, 12, 99, 0, 0, 1'b1, "R7 load beats tick");
        do_tick("R8 R1 strobe and seconds step");
        do_idle("R9 hold and strobe drops R8");
        do_tick("R2 R3 R4 full rollover with century flip");
        do_idle("R8 strobe one cycle");

        // R4 disabled century
        cen_en_i = 1'b0;
        do_load(59, 59, 23, 3, 31, 12, 99, 1, 0, 1'b0, "R7 load");
        do_tick("R4 century held when disabled");

        // R3 month lengths and leap rule
        do_load(59, 59, 23, 1, 28, 2, 24, 0, 0, 1'b0, "R7 load");
        do_tick("R3 leap year Feb 28 to 29");
        do_load(59, 59, 23, 2, 29, 2, 24, 0, 0, 1'b0, "R7 load");
        do_tick("R3 leap Feb 29 to Mar 01");
        do_load(59, 59, 23, 2, 28, 2, 23, 0, 0, 1'b0, "R7 load");
        do_tick("R3 common Feb 28 to Mar 01");
        do_load(59, 59, 23, 2, 28, 2, 0, 0, 0, 1'b0, "R7 load");
        do_tick("R3 year 00 is leap");
        do_load(59, 59, 23, 4, 30, 4, 10, 0, 0, 1'b0, "R7 load");
        do_tick("R3 30-day month wrap");
        do_load(59, 59, 23, 5, 31, 1, 10, 0, 0, 1'b0, "R7 load");
        do_tick("R3 31-day month to Feb");
        do_load(59, 59, 23, 6, 30, 11, 10, 0, 0, 1'b0, "R7 load");
        do_tick("R3 November wrap");

        // R1 minute carry only
        do_load(59, 15, 10, 2, 5, 6, 30, 0, 0, 1'b0, "R7 load");
        do_tick("R1 seconds wrap carries minute");

        // R5 halt by load, then release
        do_load(10, 20, 8, 2, 5, 6, 30, 0, 1, 1'b0, "R7 load halted");
        do_tick("R5 halted tick ignored");
        do_idle("R5 halted hold");
        do_load(10, 20, 8, 2, 5, 6, 30, 0, 0, 1'b0, "R7 load release");
        do_tick("R5 first tick after release advances");

        // long run through minute and hour carries
        do_load(0, 58, 23, 7, 31, 12, 98, 0, 0, 1'b0, "R7 load long run");
        for (int i = 0; i < 3700; i++) begin
            if (i % 5 == 4) do_idle("R9 idle inside run");
            else            do_tick("R1 R2 long run");
        end
        do_idle("R9 final hold");
        repeat (4) @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule